// File: doc/BRIEF.md
# Counter Latch and Byte Sequencer

This block is the host-side byte port for one 16-bit timer counter. A host with an 8-bit data path programs the counter's 16-bit reload value through byte writes. The programmed access mode decides which half of the reload value each write touches. The block raises a one-cycle pulse each time a reload value is complete. The counting logic that consumes this pulse lies outside the block.

Reads also arrive one byte at a time, and each read pair returns the low byte first. The source is a frozen snapshot of the live count when a latch command is held, and the live count when no latch is held. Reading the high byte of a snapshot releases it.

A command strobe with a two-bit mode field does one of two things. It either takes a snapshot, or it selects a new access mode and restarts both byte sequencers.

Top module: `cnt_access_port`

## Requirements
- R1: After reset, `rd_data`, `reload_val` and `load_done` are zero, the first read returns a low byte, and the access mode is low byte followed by high byte.
- R2: A command with `cmd_mode` = 2'b00 (latch) while no latch is held copies `live_cnt` into the snapshot, and later reads return the snapshot even if `live_cnt` changes.
- R3: A latch command while a latch is held has no effect, and the earlier snapshot stays in place.
- R4: Each accepted read returns, one cycle later on `rd_data`, the byte the read toggle selects (low byte, bits 7:0, when the toggle is clear; high byte, bits 15:8, when it is set), then flips the toggle.
- R5: Reading the high byte while a latch is held releases the latch, so subsequent reads follow `live_cnt`.
- R6: In mode 2'b11 (low then high), the first write sets bits 7:0 of `reload_val`. The second write sets bits 15:8 and completes the load.
- R7: In mode 2'b01 (low only), every write sets bits 7:0, keeps bits 15:8 and completes a load.
- R8: In mode 2'b10 (high only), every write sets bits 15:8, keeps bits 7:0 and completes a load.
- R9: A command with a nonzero `cmd_mode` selects that mode, points the write sequencer at its first byte and points the read toggle at the low byte.
- R10: `load_done` is high for exactly the one cycle after each write that completes a load, and low otherwise.
- R11: A write or read strobe in the same cycle as `cmd_stb` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| rd_stb | input | 1 | Byte read strobe |
| rd_data | output | 8 | Byte returned by the last accepted read |
| cmd_stb | input | 1 | Command strobe |
| cmd_mode | input | 2 | 00 latch, 01 low only, 10 high only, 11 low then high |
| live_cnt | input | 16 | Live counter value |
| reload_val | output | 16 | Assembled reload value |
| load_done | output | 1 | One-cycle pulse when a reload value is complete |

## Verification
The assertions assume that every strobe is a single-cycle request and that `live_cnt` is stable at the clock edge where a latch or read is accepted. They also assume that a command strobe wins over any data strobe in the same cycle, so a data strobe that arrives with a command has no effect. The stimulus changes `live_cnt` only on the falling edge, and it holds each strobe for exactly one rising edge. The random phase deliberately raises command, write and read strobes together, so the cases where a command wins are exercised often.

// File: rtl/cnt_access_port.sv
module cnt_access_port #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_stb,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic                cmd_stb,
  input  logic [1:0]          cmd_mode,
  input  logic [2*BYTE_W-1:0] live_cnt,
  output logic [2*BYTE_W-1:0] reload_val,
  output logic                load_done
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [1:0] AM_LATCH = 2'b00;
  localparam logic [1:0] AM_LO    = 2'b01;
  localparam logic [1:0] AM_HI    = 2'b10;
  localparam logic [1:0] AM_LOHI  = 2'b11;

  logic [1:0]       mode_q;
  logic             wr_hi_q;
  logic             rd_hi_q;
  logic             held_q;
  logic [CNT_W-1:0] snap_q;

  wire is_latch = cmd_stb && (cmd_mode == AM_LATCH);
  wire is_prog  = cmd_stb && (cmd_mode != AM_LATCH);
  wire wr_go    = wr_stb && !cmd_stb;
  wire rd_go    = rd_stb && !cmd_stb;

  wire [CNT_W-1:0] rd_src = held_q ? snap_q : live_cnt;
  wire wr_to_hi = (mode_q == AM_HI) || ((mode_q == AM_LOHI) && wr_hi_q);
  wire wr_done  = wr_go && ((mode_q != AM_LOHI) || wr_hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= AM_LOHI;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      held_q     <= 1'b0;
      snap_q     <= '0;
      rd_data    <= '0;
      reload_val <= '0;
      load_done  <= 1'b0;
    end else begin
      load_done <= wr_done;

      if (is_latch && !held_q) begin
        snap_q <= live_cnt;
        held_q <= 1'b1;
      end

      if (is_prog) begin
        mode_q  <= cmd_mode;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end

      if (wr_go) begin
        if (wr_to_hi) reload_val[CNT_W-1:BYTE_W] <= wr_data;
        else          reload_val[BYTE_W-1:0]     <= wr_data;
        if (mode_q == AM_LOHI) wr_hi_q <= !wr_hi_q;
      end

      if (rd_go) begin
        rd_data <= rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
        rd_hi_q <= !rd_hi_q;
        if (rd_hi_q && held_q) held_q <= 1'b0;
      end
    end
  end
endmodule

module cnt_access_port_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_stb,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                rd_stb,
  input logic                cmd_stb,
  input logic [1:0]          cmd_mode,
  input logic [2*BYTE_W-1:0] live_cnt,
  input logic [2*BYTE_W-1:0] reload_val,
  input logic                load_done,
  input logic [1:0]          mode_q,
  input logic                wr_hi_q,
  input logic                rd_hi_q,
  input logic                held_q,
  input logic [2*BYTE_W-1:0] snap_q
);
  localparam int CNT_W = 2 * BYTE_W;

  // R2
  latch_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_mode == 2'b00 && !held_q) |=> (held_q && snap_q == $past(live_cnt)));

  // R3
  latch_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_mode == 2'b00 && held_q) |=> $stable(snap_q));

  // R4
  read_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !cmd_stb) |=> (rd_hi_q != $past(rd_hi_q)));

  // R5
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !cmd_stb && held_q && rd_hi_q) |=> !held_q);

  // R7
  low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cmd_stb && mode_q == 2'b01) |=>
      (load_done && reload_val[BYTE_W-1:0] == $past(wr_data)
       && reload_val[CNT_W-1:BYTE_W] == $past(reload_val[CNT_W-1:BYTE_W])));

  // R8
  high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !cmd_stb && mode_q == 2'b10) |=>
      (load_done && reload_val[CNT_W-1:BYTE_W] == $past(wr_data)
       && reload_val[BYTE_W-1:0] == $past(reload_val[BYTE_W-1:0])));

  // R9
  prog_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && cmd_mode != 2'b00) |=> (!rd_hi_q && !wr_hi_q && mode_q == $past(cmd_mode)));

  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(wr_stb && !cmd_stb));

  // R11
  cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> ($stable(reload_val) && !load_done));
endmodule

bind cnt_access_port cnt_access_port_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
  .cmd_stb(cmd_stb), .cmd_mode(cmd_mode), .live_cnt(live_cnt),
  .reload_val(reload_val), .load_done(load_done), .mode_q(mode_q),
  .wr_hi_q(wr_hi_q), .rd_hi_q(rd_hi_q), .held_q(held_q), .snap_q(snap_q)
);

// File: tb/test_cnt_access_port.sv
module test_cnt_access_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_stb = 1'b0;
  logic [7:0]  rd_data;
  logic        cmd_stb = 1'b0;
  logic [1:0]  cmd_mode = '0;
  logic [15:0] live_cnt = '0;
  logic [15:0] reload_val;
  logic        load_done;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_reload = '0;
  logic [15:0] m_snap = '0;
  logic        m_held = 1'b0;
  logic        m_rdhi = 1'b0;
  logic        m_wrhi = 1'b0;
  logic [1:0]  m_mode = 2'b11;
  logic [7:0]  m_rd = '0;
  logic        m_done = 1'b0;

  always #5 clk = ~clk;

  cnt_access_port i_cnt_access_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .cmd_stb(cmd_stb), .cmd_mode(cmd_mode),
    .live_cnt(live_cnt), .reload_val(reload_val), .load_done(load_done)
  );

  function automatic logic [7:0] pick_byte(logic [15:0] v, logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit c, logic [1:0] m, bit w, logic [7:0] d,
                      bit r, logic [15:0] live);
    logic [15:0] src;
    @(negedge clk);
    cmd_stb = c; cmd_mode = m; wr_stb = w; wr_data = d; rd_stb = r; live_cnt = live;
    m_done = 1'b0;
    if (c) begin
      if (m == 2'b00) begin
        if (!m_held) begin m_snap = live; m_held = 1'b1; end
      end else begin
        m_mode = m; m_wrhi = 1'b0; m_rdhi = 1'b0;
      end
    end else begin
      if (w) begin
        case (m_mode)
          2'b01: begin m_reload[7:0] = d; m_done = 1'b1; end
          2'b10: begin m_reload[15:8] = d; m_done = 1'b1; end
          default: begin
            if (!m_wrhi) begin m_reload[7:0] = d; m_wrhi = 1'b1; end
            else begin m_reload[15:8] = d; m_wrhi = 1'b0; m_done = 1'b1; end
          end
        endcase
      end
      if (r) begin
        src = m_held ? m_snap : live;
        m_rd = pick_byte(src, m_rdhi);
        if (m_rdhi && m_held) m_held = 1'b0;
        m_rdhi = !m_rdhi;
      end
    end
    @(negedge clk);
    cmd_stb = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    check(tag, "reload_val", reload_val, m_reload);
    check(tag, "load_done", {15'd0, load_done}, {15'd0, m_done});
    check(tag, "rd_data", {8'd0, rd_data}, {8'd0, m_rd});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "rd_data", {8'd0, rd_data}, 16'd0);
    check("R1", "reload_val", reload_val, 16'd0);
    check("R1", "load_done", {15'd0, load_done}, 16'd0);
    rst_n = 1'b1;
    // R1 default mode is low then high; R6 / R10 pulse on second write
    step("R6", 0, 2'b00, 1, 8'h34, 0, 16'h0000);
    step("R6", 0, 2'b00, 1, 8'h12, 0, 16'h0000);
    // R1 first read is the low byte of the live count
    step("R1", 0, 2'b00, 0, 8'h00, 1, 16'hBEEF);
    step("R4", 0, 2'b00, 0, 8'h00, 1, 16'hBEEF);
    // R2 latch then move live count
    step("R2", 1, 2'b00, 0, 8'h00, 0, 16'hABCD);
    step("R2", 0, 2'b00, 0, 8'h00, 1, 16'h1111);
    step("R5", 0, 2'b00, 0, 8'h00, 1, 16'h2222);
    step("R5", 0, 2'b00, 0, 8'h00, 1, 16'h5678);
    step("R4", 0, 2'b00, 0, 8'h00, 1, 16'h5678);
    // R3 second latch ignored
    step("R3", 1, 2'b00, 0, 8'h00, 0, 16'h0102);
    step("R3", 1, 2'b00, 0, 8'h00, 0, 16'h0304);
    step("R3", 0, 2'b00, 0, 8'h00, 1, 16'h0506);
    step("R3", 0, 2'b00, 0, 8'h00, 1, 16'h0506);
    // R7 low only
    step("R7", 1, 2'b01, 0, 8'h00, 0, 16'h0000);
    step("R7", 0, 2'b00, 1, 8'h99, 0, 16'h0000);
    step("R7", 0, 2'b00, 1, 8'h98, 0, 16'h0000);
    // R8 high only
    step("R8", 1, 2'b10, 0, 8'h00, 0, 16'h0000);
    step("R8", 0, 2'b00, 1, 8'h77, 0, 16'h0000);
    step("R8", 0, 2'b00, 1, 8'h76, 0, 16'h0000);
    // R9 restart write sequencer and read toggle
    step("R9", 1, 2'b11, 0, 8'h00, 0, 16'h0000);
    step("R9", 0, 2'b00, 1, 8'hAA, 1, 16'hC3A5);
    step("R9", 1, 2'b11, 0, 8'h00, 0, 16'hC3A5);
    step("R9", 0, 2'b00, 1, 8'hBB, 1, 16'hC3A5);
    step("R10", 0, 2'b00, 1, 8'hCC, 0, 16'hC3A5);
    step("R10", 0, 2'b00, 0, 8'h00, 0, 16'hC3A5);
    // R11 command wins over data strobes
    step("R11", 1, 2'b01, 1, 8'h55, 1, 16'h4242);
    step("R11", 1, 2'b00, 1, 8'h66, 1, 16'h4343);
    step("R11", 0, 2'b00, 0, 8'h00, 1, 16'h4444);
    // random mix covering R2..R11
    for (int i = 0; i < 600; i++) begin
      v = 16'($urandom);
      step("R4", ($urandom % 5) == 0, 2'($urandom), ($urandom % 2) == 0, 8'($urandom),
           ($urandom % 2) == 0, v);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule